// File: doc/BRIEF.md
# Processor Status Register with Exception Backup

This block holds the 32-bit status word of a small CPU core. Three live bits steer the core. The condition flag holds the carry, borrow or overflow result of the last instruction that sets it. The interrupt-enable bit gates incoming interrupt requests. The stack-mode bit chooses which physical stack pointer general register 15 refers to. A second set of three bits, the backup field, keeps a copy of the live bits while an exception, interrupt or trap is being handled.

An entry strobe copies the live bits into the backup field. In the same cycle it clears stack mode and interrupt enable, which masks further interrupts and selects the interrupt stack. A return strobe copies the backup bits back into the live field in one cycle. Software can read and write all six bits through a control-register port. The ALU can update the condition flag.

A fixed priority picks one update per cycle. Exception entry comes first, then return, then a software write, then the ALU condition update. Reads are combinational from the register, so an update made at a clock edge is visible right after that edge.

Top module: `psw_ctrl`

## Requirements
- R1: After reset, the live bits (bits 0, 6 and 7) and every reserved bit of `cr_rdata` read 0. The value of the backup bits after reset is not relied upon.
- R2: Every bit position other than 0, 6, 7, 8, 14 and 15 always reads 0, whatever value was written to it.
- R3: A write with `cr_wr_en` loads the condition flag from bit 0, interrupt enable from bit 6, stack mode from bit 7, backup condition from bit 8, backup interrupt enable from bit 14 and backup stack mode from bit 15 of `cr_wdata`. The new value is readable after the next rising edge.
- R4: On `exc_enter`, the backup stack mode, interrupt enable and condition take the values of the live stack mode, interrupt enable and condition. In the same cycle live stack mode and interrupt enable go to 0, and the live condition keeps its value.
- R5: On `exc_return`, the live stack mode, interrupt enable and condition take the backup values in one cycle, and the backup bits are unchanged.
- R6: Only one update is applied per cycle, in this order of priority: `exc_enter`, then `exc_return`, then a software write, then an ALU condition update. An update that loses is dropped.
- R7: `alu_c_valid`, when it is the only update, loads the condition flag from `alu_c_value` and leaves the other five bits unchanged.
- R8: `irq_accept` is high only when `irq_req` is high and live interrupt enable is 1. It follows combinationally in the same cycle.
- R9: When `gpr_idx` is 15, stack mode 0 raises `r15_to_isp` and stack mode 1 raises `r15_to_usp`. For any other index both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_wdata | input | 32 | Control-register write data |
| cr_rdata | output | 32 | Current status word |
| exc_enter | input | 1 | Exception/interrupt/trap entry strobe |
| exc_return | input | 1 | Return-from-exception strobe |
| alu_c_valid | input | 1 | ALU condition update strobe |
| alu_c_value | input | 1 | New condition value from the ALU |
| irq_req | input | 1 | Interrupt request |
| irq_accept | output | 1 | Interrupt request gated by interrupt enable |
| gpr_idx | input | 4 | General register index being accessed |
| r15_to_isp | output | 1 | Register 15 access goes to the interrupt stack pointer |
| r15_to_usp | output | 1 | Register 15 access goes to the user stack pointer |

## Verification
Every register update (write, entry, return, ALU) appears on `cr_rdata` exactly one rising edge after the strobe. The bench drives strobes after a falling edge and reads the status word one time step after the next rising edge, then clears the strobes. `irq_accept` and the register-15 selects have no register of their own. They are checked in the same cycle as their inputs, once the status bits they depend on have settled.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int unsigned PSW_W   = 32;
    localparam int unsigned POS_C   = 0;
    localparam int unsigned POS_IE  = 6;
    localparam int unsigned POS_SM  = 7;
    localparam int unsigned POS_BC  = 8;
    localparam int unsigned POS_BIE = 14;
    localparam int unsigned POS_BSM = 15;

    typedef struct packed {
        logic sm;
        logic ie;
        logic c;
    } flags_t;

    typedef enum logic [2:0] {
        UPD_HOLD   = 3'd0,
        UPD_ALU    = 3'd1,
        UPD_WRITE  = 3'd2,
        UPD_RETURN = 3'd3,
        UPD_ENTER  = 3'd4
    } upd_src_e;

    function automatic logic [PSW_W-1:0] pack_word(flags_t live, flags_t bkup);
        logic [PSW_W-1:0] w;
        w = '0;
        w[POS_C]   = live.c;
        w[POS_IE]  = live.ie;
        w[POS_SM]  = live.sm;
        w[POS_BC]  = bkup.c;
        w[POS_BIE] = bkup.ie;
        w[POS_BSM] = bkup.sm;
        return w;
    endfunction

    function automatic flags_t live_of(logic [PSW_W-1:0] w);
        flags_t f;
        f.sm = w[POS_SM];
        f.ie = w[POS_IE];
        f.c  = w[POS_C];
        return f;
    endfunction

    function automatic flags_t bkup_of(logic [PSW_W-1:0] w);
        flags_t f;
        f.sm = w[POS_BSM];
        f.ie = w[POS_BIE];
        f.c  = w[POS_BC];
        return f;
    endfunction

endpackage

// File: rtl/psw_update_arb.sv
module psw_update_arb
    import psw_pkg::*;
(
    input  logic     enter_i,
    input  logic     return_i,
    input  logic     write_i,
    input  logic     alu_i,
    output upd_src_e src_o
);

    always_comb begin
        if (enter_i) begin
            src_o = UPD_ENTER;
        end else if (return_i) begin
            src_o = UPD_RETURN;
        end else if (write_i) begin
            src_o = UPD_WRITE;
        end else if (alu_i) begin
            src_o = UPD_ALU;
        end else begin
            src_o = UPD_HOLD;
        end
    end

endmodule

// File: rtl/psw_fields.sv
module psw_fields
    import psw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  upd_src_e         src_i,
    input  logic [PSW_W-1:0] wdata_i,
    input  logic             alu_c_i,
    output flags_t           live_o,
    output flags_t           bkup_o
);

    flags_t live_q, live_d;
    flags_t bkup_q, bkup_d;

    always_comb begin
        live_d = live_q;
        bkup_d = bkup_q;
        unique case (src_i)
            UPD_HOLD: begin
            end
            UPD_ALU: begin
                live_d.c = alu_c_i;
            end
            UPD_WRITE: begin
                live_d = live_of(wdata_i);
                bkup_d = bkup_of(wdata_i);
            end
            UPD_RETURN: begin
                live_d = bkup_q;
            end
            UPD_ENTER: begin
                bkup_d  = live_q;
                live_d.sm = 1'b0;
                live_d.ie = 1'b0;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
            bkup_q <= '0;
        end else begin
            live_q <= live_d;
            bkup_q <= bkup_d;
        end
    end

    assign live_o = live_q;
    assign bkup_o = bkup_q;

endmodule

// File: rtl/psw_sideband.sv
module psw_sideband #(
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned SP_REG_IDX = 15
) (
    input  logic             sm_i,
    input  logic             ie_i,
    input  logic             irq_req_i,
    input  logic [IDX_W-1:0] gpr_idx_i,
    output logic             irq_accept_o,
    output logic             r15_isp_o,
    output logic             r15_usp_o
);

    localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(SP_REG_IDX);

    logic is_sp;

    assign is_sp        = (gpr_idx_i == SP_IDX);
    assign irq_accept_o = irq_req_i & ie_i;
    assign r15_isp_o    = is_sp & ~sm_i;
    assign r15_usp_o    = is_sp & sm_i;

endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
    import psw_pkg::*;
#(
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned SP_REG_IDX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cr_wr_en,
    input  logic [PSW_W-1:0] cr_wdata,
    output logic [PSW_W-1:0] cr_rdata,
    input  logic             exc_enter,
    input  logic             exc_return,
    input  logic             alu_c_valid,
    input  logic             alu_c_value,
    input  logic             irq_req,
    output logic             irq_accept,
    input  logic [IDX_W-1:0] gpr_idx,
    output logic             r15_to_isp,
    output logic             r15_to_usp
);

    upd_src_e src;
    flags_t   live;
    flags_t   bkup;

    psw_update_arb u_arb (
        .enter_i  (exc_enter),
        .return_i (exc_return),
        .write_i  (cr_wr_en),
        .alu_i    (alu_c_valid),
        .src_o    (src)
    );

    psw_fields u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .wdata_i (cr_wdata),
        .alu_c_i (alu_c_value),
        .live_o  (live),
        .bkup_o  (bkup)
    );

    psw_sideband #(
        .IDX_W      (IDX_W),
        .SP_REG_IDX (SP_REG_IDX)
    ) u_side (
        .sm_i         (live.sm),
        .ie_i         (live.ie),
        .irq_req_i    (irq_req),
        .gpr_idx_i    (gpr_idx),
        .irq_accept_o (irq_accept),
        .r15_isp_o    (r15_to_isp),
        .r15_usp_o    (r15_to_usp)
    );

    assign cr_rdata = pack_word(live, bkup);

endmodule

// File: rtl/psw_ctrl_checker.sv
module psw_ctrl_checker
    import psw_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cr_wr_en,
    input logic [PSW_W-1:0] cr_wdata,
    input logic [PSW_W-1:0] cr_rdata,
    input logic             exc_enter,
    input logic             exc_return,
    input logic             alu_c_valid,
    input logic             alu_c_value,
    input logic             irq_req,
    input logic             irq_accept,
    input logic [IDX_W-1:0] gpr_idx,
    input logic             r15_to_isp,
    input logic             r15_to_usp
);

    localparam logic [PSW_W-1:0] NAMED = (PSW_W'(1) << POS_C)  | (PSW_W'(1) << POS_IE) |
                                         (PSW_W'(1) << POS_SM) | (PSW_W'(1) << POS_BC) |
                                         (PSW_W'(1) << POS_BIE)| (PSW_W'(1) << POS_BSM);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_rdata & ~NAMED) == '0);

    a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr_en && !exc_enter && !exc_return) |=> cr_rdata == ($past(cr_wdata) & NAMED));

    a_r4_entry_backup: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (cr_rdata[POS_BSM] == $past(cr_rdata[POS_SM])) &&
                      (cr_rdata[POS_BIE] == $past(cr_rdata[POS_IE])) &&
                      (cr_rdata[POS_BC]  == $past(cr_rdata[POS_C])));

    a_r4_entry_mask: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> !cr_rdata[POS_SM] && !cr_rdata[POS_IE] &&
                      (cr_rdata[POS_C] == $past(cr_rdata[POS_C])));

    a_r5_return_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter) |=>
            (cr_rdata[POS_SM] == $past(cr_rdata[POS_BSM])) &&
            (cr_rdata[POS_IE] == $past(cr_rdata[POS_BIE])) &&
            (cr_rdata[POS_C]  == $past(cr_rdata[POS_BC]))  &&
            $stable(cr_rdata[POS_BSM]) && $stable(cr_rdata[POS_BIE]) && $stable(cr_rdata[POS_BC]));

    a_r7_alu_only_c: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_c_valid && !cr_wr_en && !exc_enter && !exc_return) |=>
            (cr_rdata[POS_C] == $past(alu_c_value)) &&
            ((cr_rdata & ~(PSW_W'(1) << POS_C)) == ($past(cr_rdata) & ~(PSW_W'(1) << POS_C))));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_c_valid && !cr_wr_en && !exc_enter && !exc_return) |=> $stable(cr_rdata));

    a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept == (irq_req && cr_rdata[POS_IE]));

    a_r9_sp_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r15_to_isp, r15_to_usp}) &&
        (r15_to_usp == ((gpr_idx == IDX_W'(15)) && cr_rdata[POS_SM])));

    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r9_no_sp_off_idx: assert ((gpr_idx == IDX_W'(15)) || (!r15_to_isp && !r15_to_usp));
        end
    end

endmodule

bind psw_ctrl psw_ctrl_checker #(.IDX_W(IDX_W)) u_psw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cr_wr_en    (cr_wr_en),
    .cr_wdata    (cr_wdata),
    .cr_rdata    (cr_rdata),
    .exc_enter   (exc_enter),
    .exc_return  (exc_return),
    .alu_c_valid (alu_c_valid),
    .alu_c_value (alu_c_value),
    .irq_req     (irq_req),
    .irq_accept  (irq_accept),
    .gpr_idx     (gpr_idx),
    .r15_to_isp  (r15_to_isp),
    .r15_to_usp  (r15_to_usp)
);

// File: tb/psw_ctrl_bench.sv
module psw_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 16;

    // row: {wr, enter, ret, alu_v, alu_c, wdata[31:0], expected[31:0]}
    localparam logic [68:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_C1C1}, // R3 R2 all ones
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000}, // R3 clear
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_00C1, 32'h0000_00C1}, // R3 live only
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_C101}, // R4 entry
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_C100}, // R7 alu c=0
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_C1C1}, // R5 return
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_4100, 32'h0000_4100}, // R3 backup only
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_4141}, // R5 return
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_4101}, // R6 entry beats write
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0080, 32'h0000_4141}, // R6 return beats write
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0080, 32'h0000_0080}, // R6 write beats alu
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0081}, // R7 alu c=1
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_8101}, // R6 entry beats return
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_8181}, // R6 return beats alu
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h5A5A_5A5A, 32'h0000_4040}, // R2 R3 pattern
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_4040}  // R6 idle hold
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cr_wr_en = 1'b0;
    logic [31:0] cr_wdata = '0;
    logic [31:0] cr_rdata;
    logic        exc_enter = 1'b0;
    logic        exc_return = 1'b0;
    logic        alu_c_valid = 1'b0;
    logic        alu_c_value = 1'b0;
    logic        irq_req = 1'b0;
    logic        irq_accept;
    logic [3:0]  gpr_idx = '0;
    logic        r15_to_isp;
    logic        r15_to_usp;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psw_ctrl u_psw_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cr_wr_en    (cr_wr_en),
        .cr_wdata    (cr_wdata),
        .cr_rdata    (cr_rdata),
        .exc_enter   (exc_enter),
        .exc_return  (exc_return),
        .alu_c_valid (alu_c_valid),
        .alu_c_value (alu_c_value),
        .irq_req     (irq_req),
        .irq_accept  (irq_accept),
        .gpr_idx     (gpr_idx),
        .r15_to_isp  (r15_to_isp),
        .r15_to_usp  (r15_to_usp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic wr, input logic en, input logic rt,
                         input logic av, input logic ac, input logic [31:0] wd);
        @(negedge clk);
        cr_wr_en    = wr;
        exc_enter   = en;
        exc_return  = rt;
        alu_c_valid = av;
        alu_c_value = ac;
        cr_wdata    = wd;
        @(posedge clk);
        #1;
        cr_wr_en    = 1'b0;
        exc_enter   = 1'b0;
        exc_return  = 1'b0;
        alu_c_valid = 1'b0;
        alu_c_value = 1'b0;
        cr_wdata    = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual expired expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: live and reserved bits zero; backup bits masked off
        check("R1 reset", cr_rdata & ~32'h0000_C100, 32'h0);
        check("R8 reset irq masked", {31'b0, irq_accept}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][68], VEC[i][67], VEC[i][66], VEC[i][65], VEC[i][64], VEC[i][63:32]);
            check($sformatf("R2-R7 vector %0d", i), cr_rdata, VEC[i][31:0]);
        end

        // R8: interrupt gating, combinational in the same cycle
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000);
        irq_req = 1'b1;
        #1;
        check("R8 ie=0 req=1", {31'b0, irq_accept}, 32'h0);
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0040);
        check("R8 ie=1 req=1", {31'b0, irq_accept}, 32'h1);
        irq_req = 1'b0;
        #1;
        check("R8 ie=1 req=0", {31'b0, irq_accept}, 32'h0);
        irq_req = 1'b1;
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R8 masked after entry (R4)", {31'b0, irq_accept}, 32'h0);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
        check("R8 unmasked after return (R5)", {31'b0, irq_accept}, 32'h1);
        irq_req = 1'b0;

        // R9: register 15 bank select
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000);
        gpr_idx = 4'd15;
        #1;
        check("R9 sm=0 idx15", {30'b0, r15_to_isp, r15_to_usp}, 32'h2);
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0080);
        check("R9 sm=1 idx15", {30'b0, r15_to_isp, r15_to_usp}, 32'h1);
        gpr_idx = 4'd3;
        #1;
        check("R9 sm=1 idx3", {30'b0, r15_to_isp, r15_to_usp}, 32'h0);
        gpr_idx = 4'd15;
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R9 entry selects isp (R4)", {30'b0, r15_to_isp, r15_to_usp}, 32'h2);
        gpr_idx = 4'd14;
        #1;
        check("R9 sm=0 idx14", {30'b0, r15_to_isp, r15_to_usp}, 32'h0);

        // R2: reserved-only write leaves everything zero
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_3E3E);
        check("R2 reserved-only write", cr_rdata, 32'h0);

        // R1: reset again mid-run clears live bits
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_00C1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", cr_rdata & ~32'h0000_C100, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        finish_run();
    end

endmodule